// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a 16-bit logical offset and an access class into a 20-bit physical byte address. It keeps four 16-bit segment bases: code, stack, data and extra. A plain load port writes these bases. For each accepted request, the unit first picks a default segment from the access class. It then applies an explicit override where the class permits one. Finally it forms the address as the chosen base times sixteen plus the offset, wrapping at 1 MiB.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream after one register stage. Each result carries the physical address and the index of the segment that was used. A result stays on the output until the consumer takes it. While a result is waiting, the input is back-pressured. When the output stage is empty, or is emptying in the same cycle, the unit takes one request per cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset (rst_n low) is asserted, rsp_valid is 0 and all four segment bases are cleared to 0000h.
- R2: When ld_en is high at a clock edge, the base chosen by ld_sel (0 code, 1 stack, 2 data, 3 extra) takes ld_base. A request accepted at that same edge still uses the previous value of that base.
- R3: rsp_addr equals (base << 4) + offset, kept modulo 2^20. For example, base FFFFh with offset FFFFh gives 0FFEFh.
- R4: The default segment for each req_class value is:
  - 0 (instruction fetch): code
  - 1 (stack push/pop): stack
  - 2 (base-pointer data): stack
  - 3 (ordinary data): data
  - 4 (string destination): extra
  - 5 to 7: treated as class 3 (ordinary data)
- R5: For classes 2, 3 and 5 to 7, when req_ovr_en is 1, the segment req_ovr_sel is used instead of the default. req_ovr_sel uses the same encoding as ld_sel.
- R6: For classes 0, 1 and 4, req_ovr_en and req_ovr_sel are ignored and the default segment is used. Class 4 always uses extra.
- R7: rsp_seg reports the segment index that was used to form rsp_addr, in the ld_sel encoding.
- R8: A request is accepted when req_valid and req_ready are both high at a clock edge. req_ready equals (!rsp_valid || rsp_ready). The result is presented with rsp_valid high in the next cycle.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_addr and rsp_seg stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write strobe for a segment base |
| ld_sel | input | 2 | Base to write (0 code, 1 stack, 2 data, 3 extra) |
| ld_base | input | 16 | New base value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_offset | input | 16 | Logical offset |
| req_class | input | 3 | Access class |
| req_ovr_en | input | 1 | Override requested |
| req_ovr_sel | input | 2 | Segment named by the override |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_addr | output | 20 | Physical byte address |
| rsp_seg | output | 2 | Segment index used |

## Verification
The hardest case to reach from the ports has two parts. A base load and a request that reads the same base land on one edge. At the same time, the output is stalled, so a second request must wait for the first to drain. The bench drives a load and a request in the same cycle and expects the old base. It then holds rsp_ready low across several cycles while a second request is pending, and releases it. The bench checks that the held result did not move and that the pending request is taken on the release edge. Random traffic also mixes override requests into every class, so each ignored-override path is seen many times.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int OFS_W  = 16;
  localparam int SHIFT  = 4;
  localparam int NSEG   = 4;
  localparam int SEG_W  = $clog2(NSEG);
  localparam int CLS_W  = 3;

  localparam logic [SEG_W-1:0] SEG_CODE  = 2'd0;
  localparam logic [SEG_W-1:0] SEG_STACK = 2'd1;
  localparam logic [SEG_W-1:0] SEG_DATA  = 2'd2;
  localparam logic [SEG_W-1:0] SEG_EXTRA = 2'd3;

  localparam logic [CLS_W-1:0] CLS_FETCH   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_STACKOP = 3'd1;
  localparam logic [CLS_W-1:0] CLS_BPDATA  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_DATA    = 3'd3;
  localparam logic [CLS_W-1:0] CLS_STRDST  = 3'd4;
endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs
  import seg_addr_pkg::*;
#(
  parameter int W = OFS_W,
  parameter int N = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [W-1:0]  ld_base,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_base
);
  logic [W-1:0] bases [N];

  for (genvar g = 0; g < N; g++) begin : g_base
    always_ff @(posedge clk) begin
      if (!rst_n)                          bases[g] <= '0;
      else if (ld_en && ld_sel == SW'(g))  bases[g] <= ld_base;
    end
  end

  assign rd_base = bases[rd_sel];

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> bases[$past(ld_sel)] == $past(ld_base));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             ovr_en,
  input  logic [SEG_W-1:0] ovr_sel,
  output logic [SEG_W-1:0] seg
);
  logic [SEG_W-1:0] dflt;
  logic             fixed;

  always_comb begin
    fixed = 1'b0;
    unique case (cls)
      CLS_FETCH:   begin dflt = SEG_CODE;  fixed = 1'b1; end
      CLS_STACKOP: begin dflt = SEG_STACK; fixed = 1'b1; end
      CLS_BPDATA:  dflt = SEG_STACK;
      CLS_STRDST:  begin dflt = SEG_EXTRA; fixed = 1'b1; end
      default:     dflt = SEG_DATA;
    endcase
    seg = (ovr_en && !fixed) ? ovr_sel : dflt;
  end
endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
  parameter int W  = 16,
  parameter int SH = 4,
  localparam int AW = W + SH
) (
  input  logic [W-1:0]  base,
  input  logic [W-1:0]  offset,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] shifted, widened;
  assign shifted = {base, {SH{1'b0}}};
  assign widened = {{SH{1'b0}}, offset};
  assign addr    = shifted + widened;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int W  = OFS_W,
  parameter int SH = SHIFT,
  localparam int AW = W + SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEG_W-1:0] ld_sel,
  input  logic [W-1:0]     ld_base,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [W-1:0]     req_offset,
  input  logic [CLS_W-1:0] req_class,
  input  logic             req_ovr_en,
  input  logic [SEG_W-1:0] req_ovr_sel,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [AW-1:0]    rsp_addr,
  output logic [SEG_W-1:0] rsp_seg
);
  logic [SEG_W-1:0] sel_seg;
  logic [W-1:0]     sel_base;
  logic [AW-1:0]    phys;
  logic             accept;

  seg_select u_sel (
    .cls(req_class), .ovr_en(req_ovr_en), .ovr_sel(req_ovr_sel), .seg(sel_seg)
  );

  seg_base_regs #(.W(W), .N(NSEG)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_base(ld_base),
    .rd_sel(sel_seg), .rd_base(sel_base)
  );

  seg_addr_adder #(.W(W), .SH(SH)) u_add (
    .base(sel_base), .offset(req_offset), .addr(phys)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_seg   <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= phys;
        rsp_seg  <= sel_seg;
      end
    end
  end

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_seg));
  p_fetch_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_class == CLS_FETCH |=> rsp_seg == SEG_CODE);
  p_strdst_extra_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_class == CLS_STRDST |=> rsp_seg == SEG_EXTRA);
  p_stackop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_class == CLS_STACKOP |=> rsp_seg == SEG_STACK);
endmodule

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
module tb_seg_addr_gen;
  logic clk = 0, rst_n = 0;
  logic ld_en = 0; logic [1:0] ld_sel = 0; logic [15:0] ld_base = 0;
  logic req_valid = 0, req_ready; logic [15:0] req_offset = 0;
  logic [2:0] req_class = 0; logic req_ovr_en = 0; logic [1:0] req_ovr_sel = 0;
  logic rsp_valid, rsp_ready = 1; logic [19:0] rsp_addr; logic [1:0] rsp_seg;

  int nrun = 0, nfail = 0; bit done = 0;
  logic [15:0] mb [4];

  always #4 clk = ~clk;

  seg_addr_gen dut (.*);

  function automatic logic [1:0] exp_seg(logic [2:0] c, logic oe, logic [1:0] os);
    logic [1:0] d;
    case (c)
      3'd0: return 2'd0;
      3'd1: return 2'd1;
      3'd4: return 2'd3;
      3'd2: d = 2'd1;
      default: d = 2'd2;
    endcase
    return oe ? os : d;
  endfunction

  function automatic logic [19:0] exp_addr(logic [15:0] b, logic [15:0] o);
    logic [20:0] s = {1'b0, b, 4'h0} + {5'h0, o};
    return s[19:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(logic [1:0] s, logic [15:0] v);
    @(negedge clk); ld_en = 1; ld_sel = s; ld_base = v;
    @(negedge clk); ld_en = 0; mb[s] = v;
  endtask

  task automatic req(string tag, logic [2:0] c, logic oe, logic [1:0] os, logic [15:0] off);
    logic [1:0] es;
    @(negedge clk);
    req_valid = 1; req_class = c; req_ovr_en = oe; req_ovr_sel = os; req_offset = off;
    es = exp_seg(c, oe, os);
    @(negedge clk); req_valid = 0;
    chk({tag, " valid"}, 32'(rsp_valid), 1);
    chk({tag, " seg"}, 32'(rsp_seg), 32'(es));
    chk({tag, " addr"}, 32'(rsp_addr), 32'(exp_addr(mb[es], off)));
  endtask

  initial begin
    logic [19:0] held;
    for (int i = 0; i < 4; i++) mb[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R8 ready when empty", 32'(req_ready), 1);
    req("R1 bases zero", 3'd3, 0, 0, 16'h1234);
    load(0, 16'h1000); load(1, 16'h2000); load(2, 16'h3000); load(3, 16'h4000);
    req("R4 fetch", 3'd0, 0, 0, 16'h0010);
    req("R4 stackop", 3'd1, 0, 0, 16'h0020);
    req("R4 bpdata", 3'd2, 0, 0, 16'h0030);
    req("R4 data", 3'd3, 0, 0, 16'h0040);
    req("R4 strdst", 3'd4, 0, 0, 16'h0050);
    req("R4 class7", 3'd7, 0, 0, 16'h0060);
    req("R5 data ovr extra", 3'd3, 1, 3, 16'h0070);
    req("R5 bp ovr code", 3'd2, 1, 0, 16'h0080);
    req("R6 strdst ovr ignored", 3'd4, 1, 2, 16'h0090);
    req("R6 fetch ovr ignored", 3'd0, 1, 1, 16'h00A0);
    req("R6 stackop ovr ignored", 3'd1, 1, 3, 16'h00B0);
    load(2, 16'hFFFF);
    req("R3 wrap", 3'd3, 0, 0, 16'hFFFF);
    chk("R3 wrap value", 32'(rsp_addr), 32'h0FFEF);
    // R2: load and request on the same edge, old base expected
    @(negedge clk);
    ld_en = 1; ld_sel = 2; ld_base = 16'h0ABC;
    req_valid = 1; req_class = 3; req_ovr_en = 0; req_offset = 16'h0005;
    @(negedge clk); ld_en = 0; req_valid = 0;
    chk("R2 same-edge uses old base", 32'(rsp_addr), 32'(exp_addr(16'hFFFF, 16'h0005)));
    mb[2] = 16'h0ABC;
    req("R2 new base after load", 3'd3, 0, 0, 16'h0005);
    // R9 / R8 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_class = 0; req_ovr_en = 0; req_offset = 16'h0111;
    @(negedge clk);
    held = exp_addr(mb[0], 16'h0111);
    req_class = 4; req_offset = 16'h0222;
    chk("R8 ready low when stalled", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R9 valid held", 32'(rsp_valid), 1);
    chk("R9 addr held", 32'(rsp_addr), 32'(held));
    chk("R9 seg held", 32'(rsp_seg), 0);
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    chk("R8 pending taken on release", 32'(rsp_addr), 32'(exp_addr(mb[3], 16'h0222)));
    chk("R7 seg of pending", 32'(rsp_seg), 3);
    // random traffic
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 4) == 0) load(2'($urandom), 16'($urandom));
      req("R3/R4/R5/R6/R7 random", 3'($urandom), 1'($urandom), 2'($urandom), 16'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nrun++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule